// File: doc/BRIEF.md
# Command-Driven I2C Master Sequencer

This block is an I2C bus master steered one command at a time by a host. The host sets a target word (7-bit slave address plus direction), places a byte to send, and pulses a command strobe with a 3-bit code. The code says whether to open with a START and address, whether to move one data byte, and whether to close with a STOP. A multi-byte transfer is a chain of such commands. Between commands the master keeps the bus by holding SCL low, so the host can check each byte before it asks for the next.

Outcomes are reported on status outputs. These are busy, a bus-activity flag that follows START and STOP conditions from any master, and three separate error causes with a summary bit. The bus side has open-drain SDA and SCL: each has a drive-low enable and a sampled input. The master waits while another device stretches SCL low. When it sends a one and sees the line low, it gives up the bus.

Top module: `i2c_cmd_master`

## Requirements
- R1: `target_cfg[7:1]` is the slave address and `target_cfg[0]` the direction (1 = read). The address byte is `target_cfg`, sent MSB first.
- R2: `cmd_code` bit 0 moves one byte, bit 1 opens with START plus address, and bit 2 closes with STOP. The used codes are 3'b111 single, 3'b011 burst start, 3'b001 continue, 3'b101 finish and 3'b100 error-stop.
- R3: Burst start sends START, the address and one byte, then goes idle with SCL held low and no STOP. Single and finish end with a STOP that frees both lines.
- R4: Continue moves one byte with neither START nor STOP, and the bytes of a chain arrive in command order.
- R5: In a read, each byte is placed on `rx_byte`. The master ACKs a byte whose code has no STOP bit and NACKs a byte whose code has one.
- R6: After reset all outputs are low. `st_busy` rises the cycle after an accepted strobe. The block ignores any strobe while busy, a code without bit 1 while the bus is not held, and any code with bit 0 clear while the bus is not held.
- R7: While `st_busy` is high, all four error outputs read 0.
- R8: An address NACK sets `st_addr_nack` and `st_err` and moves no data. With the STOP bit the master then issues STOP; without it the master keeps the bus until an error-stop.
- R9: A data NACK in a write sets `st_data_nack` and `st_err`, with the same STOP-or-hold choice as R8.
- R10: If a one that the master sends reads back as zero, the master releases both lines, sets `st_arb_lost` and `st_err`, and clears busy. It no longer holds the bus, so a following continue is ignored.
- R11: `st_bus_busy` sets when SDA falls while SCL is high, whichever master caused it. It clears when SDA rises while SCL is high.
- R12: While SCL is released but read low (stretched), the master waits and samples only after SCL is seen high.
- R13: A start code given while the bus is held produces a repeated START, and the new direction is taken from `target_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| target_cfg | input | 8 | Address in bits 7:1, read flag in bit 0 |
| tx_byte | input | 8 | Byte to send, captured when a command is accepted |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 3 | {stop, start, move-byte} |
| rx_byte | output | 8 | Last byte read |
| st_busy | output | 1 | Command in progress |
| st_bus_busy | output | 1 | Bus owned by some master |
| st_err | output | 1 | Any error cause present |
| st_addr_nack | output | 1 | Address was not acknowledged |
| st_data_nack | output | 1 | Data byte was not acknowledged |
| st_arb_lost | output | 1 | Arbitration lost |
| sda_low | output | 1 | Drive SDA low |
| sda_in | input | 1 | Sampled SDA |
| scl_low | output | 1 | Drive SCL low |
| scl_in | input | 1 | Sampled SCL |

## Verification
Two things can land in the same cycle: an operation finishing and a new strobe being accepted. To provoke this, the bench holds the strobe high through a whole burst-start. It then expects every strobe during the busy window to be ignored, and busy to come back exactly one cycle after it fell, with a second byte and a STOP on the bus. A second such pair is arbitration loss and bus-activity tracking, which read the same SDA edges. A foreign master pulls SDA low before the address goes out, and the bench checks that the bus stays marked busy after the master backs off and clears only when that master releases SDA.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] target_cfg,
  input  logic [7:0] tx_byte,
  input  logic       cmd_stb,
  input  logic [2:0] cmd_code,
  output logic [7:0] rx_byte,
  output logic       st_busy,
  output logic       st_bus_busy,
  output logic       st_err,
  output logic       st_addr_nack,
  output logic       st_data_nack,
  output logic       st_arb_lost,
  output logic       sda_low,
  input  logic       sda_in,
  output logic       scl_low,
  input  logic       scl_in
);
  localparam int TW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(QDIV - 1);

  typedef enum logic [2:0] {IDLE, STRT, ADR, DAT, STP} st_t;

  st_t        st;
  logic [TW-1:0] tick;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, txd;
  logic busy, held, rd, fin, nk, an, dn, al, bus_bsy, sda_q, scl_q;

  logic c_run, c_start, c_stop, go, tx_phase, bit_val, arb_chk, step;
  assign c_run   = cmd_code[0];
  assign c_start = cmd_code[1];
  assign c_stop  = cmd_code[2];
  assign go      = cmd_stb && !busy && (held ? (c_run || c_stop) : (c_start && c_run));
  assign tx_phase = (st == ADR) || !rd;
  assign bit_val = (bitn < 4'd8) ? (tx_phase ? sh[7] : 1'b1) : (tx_phase ? 1'b1 : fin);
  assign arb_chk = tx_phase && (bitn < 4'd8) && sh[7];
  assign step    = (tick == '0) && !(q == 2'd2 && !scl_in);

  assign st_busy      = busy;
  assign st_bus_busy  = bus_bsy;
  assign st_addr_nack = an && !busy;
  assign st_data_nack = dn && !busy;
  assign st_arb_lost  = al && !busy;
  assign st_err       = (an || dn || al) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tick <= '0; q <= '0; bitn <= '0; sh <= '0; txd <= '0;
      busy <= 1'b0; held <= 1'b0; rd <= 1'b0; fin <= 1'b0; nk <= 1'b0;
      an <= 1'b0; dn <= 1'b0; al <= 1'b0; rx_byte <= '0;
      sda_low <= 1'b0; scl_low <= 1'b0;
    end else if (go) begin
      busy <= 1'b1;
      fin  <= c_stop;
      an <= 1'b0; dn <= 1'b0; al <= 1'b0;
      tick <= RELOAD; q <= '0; bitn <= '0;
      txd  <= tx_byte;
      if (c_start && c_run) begin
        st <= STRT; sh <= target_cfg; rd <= target_cfg[0];
      end else if (c_run) begin
        st <= DAT; sh <= rd ? 8'h00 : tx_byte;
      end else begin
        st <= STP;
      end
    end else if (busy) begin
      if (tick != '0) begin
        tick <= tick - TW'(1);
      end else if (step) begin
        tick <= RELOAD;
        q    <= q + 2'd1;
        case (st)
          STRT: begin
            case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin scl_low <= 1'b1; st <= ADR; bitn <= '0; end
            endcase
          end
          STP: begin
            case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin busy <= 1'b0; held <= 1'b0; st <= IDLE; end
            endcase
          end
          ADR, DAT: begin
            case (q)
              2'd0: sda_low <= !bit_val;
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (arb_chk && !sda_in) begin
                  al <= 1'b1; busy <= 1'b0; held <= 1'b0; st <= IDLE;
                  sda_low <= 1'b0; scl_low <= 1'b0;
                end else if (bitn < 4'd8) begin
                  sh <= {sh[6:0], sda_in};
                end else begin
                  nk <= sda_in;
                end
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn < 4'd8) begin
                  bitn <= bitn + 4'd1;
                end else begin
                  bitn <= '0;
                  if (tx_phase && nk) begin
                    if (st == ADR) an <= 1'b1; else dn <= 1'b1;
                    if (fin) st <= STP;
                    else begin busy <= 1'b0; held <= 1'b1; st <= IDLE; end
                  end else if (st == ADR) begin
                    st <= DAT;
                    sh <= rd ? 8'h00 : txd;
                  end else begin
                    if (rd) rx_byte <= sh;
                    if (fin) st <= STP;
                    else begin busy <= 1'b0; held <= 1'b1; st <= IDLE; end
                  end
                end
              end
            endcase
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1; scl_q <= 1'b1; bus_bsy <= 1'b0;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
      if (scl_in && scl_q && sda_q && !sda_in) bus_bsy <= 1'b1;
      else if (scl_in && scl_q && !sda_q && sda_in) bus_bsy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_stb,
  input logic st_busy,
  input logic st_bus_busy,
  input logic st_err,
  input logic st_addr_nack,
  input logic st_data_nack,
  input logic st_arb_lost,
  input logic sda_low,
  input logic scl_low,
  input logic sda_in,
  input logic scl_in
);
  p_quiet_errors_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !(st_err || st_addr_nack || st_data_nack || st_arb_lost));

  p_single_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_addr_nack, st_data_nack, st_arb_lost}));

  p_cause_sets_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_addr_nack || st_data_nack || st_arb_lost) |-> st_err);

  p_arb_frees_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_arb_lost) |-> (!sda_low && !scl_low));

  p_idle_lines_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_busy && !cmd_stb) |=> ($stable(sda_low) && $stable(scl_low)));

  p_start_marks_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && $fell(sda_in)) |=> st_bus_busy);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .st_busy(st_busy),
  .st_bus_busy(st_bus_busy), .st_err(st_err), .st_addr_nack(st_addr_nack),
  .st_data_nack(st_data_nack), .st_arb_lost(st_arb_lost),
  .sda_low(sda_low), .scl_low(scl_low), .sda_in(sda_in), .scl_in(scl_in)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  localparam logic [6:0] SADDR = 7'h2A;
  localparam logic [2:0] C_SINGLE = 3'b111, C_BSTART = 3'b011, C_CONT = 3'b001,
                         C_FIN = 3'b101, C_ESTOP = 3'b100;
  localparam int STR = 40;

  logic clk = 0, rst_n = 0;
  logic [7:0] target_cfg = 0, tx_byte = 0;
  logic cmd_stb = 0;
  logic [2:0] cmd_code = 0;
  logic [7:0] rx_byte;
  logic st_busy, st_bus_busy, st_err, st_addr_nack, st_data_nack, st_arb_lost;
  logic sda_low, scl_low;
  logic s_low = 0, rogue = 0, str = 0, stretch_en = 0;
  wire sda_w = ~(sda_low | s_low | rogue);
  wire scl_w = ~(scl_low | str);

  always #10 clk = ~clk;

  i2c_cmd_master dut_i (
    .clk(clk), .rst_n(rst_n), .target_cfg(target_cfg), .tx_byte(tx_byte),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .rx_byte(rx_byte),
    .st_busy(st_busy), .st_bus_busy(st_bus_busy), .st_err(st_err),
    .st_addr_nack(st_addr_nack), .st_data_nack(st_data_nack),
    .st_arb_lost(st_arb_lost), .sda_low(sda_low), .sda_in(sda_w),
    .scl_low(scl_low), .scl_in(scl_w));

  function automatic logic [7:0] rd_val(input int i);
    return 8'h5C + 8'(i * 29);
  endfunction

  // behavioural slave
  logic s_act = 0, s_match = 0, s_mack = 0;
  int s_bc = 0, s_ph = 0, s_ridx = 0;
  logic [7:0] s_sh = 0, s_rb = 0;
  logic [7:0] wlog [0:31];
  int wcnt = 0, ack_cnt = 0, nack_cnt = 0, nack_at = -1, starts = 0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    s_act = 1; s_ph = 1; s_bc = 0; s_low = 0; starts++;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    s_act = 0; s_ph = 0; s_low = 0;
  end
  always @(posedge scl_w) if (s_act) begin
    s_bc++;
    if (s_bc <= 8 && s_ph != 3) s_sh = {s_sh[6:0], sda_w};
    if (s_bc == 9 && s_ph == 3) begin
      s_mack = !sda_w;
      if (s_mack) ack_cnt++; else nack_cnt++;
    end
  end
  always @(negedge scl_w) if (s_act) begin
    if (s_bc == 8) begin
      if (s_ph == 1) begin s_match = (s_sh[7:1] == SADDR); s_low = s_match; end
      else if (s_ph == 2) begin
        if (wcnt < 32) wlog[wcnt] = s_sh;
        s_low = (wcnt != nack_at); wcnt++;
      end else s_low = 0;
    end else if (s_bc == 9) begin
      s_bc = 0; s_low = 0;
      if (s_ph == 1) begin
        if (!s_match) s_ph = 0;
        else if (s_sh[0]) begin s_ph = 3; s_ridx = 0; end
        else s_ph = 2;
      end else if (s_ph == 3 && !s_mack) s_ph = 0;
      if (s_ph == 3) begin s_rb = rd_val(s_ridx); s_ridx++; s_low = !s_rb[7]; end
    end else if (s_ph == 3 && s_bc >= 1 && s_bc <= 7) begin
      s_low = !s_rb[7 - s_bc];
    end
  end

  always @(negedge scl_low) if (stretch_en) begin
    str = 1; repeat (STR) @(posedge clk); str = 0;
  end

  int n_chk = 0, n_fail = 0, last_dur = 0;
  logic err_seen_busy = 0;
  always @(negedge clk)
    if (st_busy && (st_err || st_addr_nack || st_data_nack || st_arb_lost)) err_seen_busy = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic run_cmd(input logic [2:0] code);
    @(negedge clk); cmd_code = code; cmd_stb = 1;
    @(negedge clk); cmd_stb = 0;
    last_dur = 1;
    while (st_busy) begin @(negedge clk); last_dur++; end
  endtask

  task automatic burst_write(input int n, input logic [7:0] d [0:7]);
    target_cfg = {SADDR, 1'b0};
    for (int i = 0; i < n; i++) begin
      tx_byte = d[i];
      run_cmd(n == 1 ? C_SINGLE : i == 0 ? C_BSTART : i == n - 1 ? C_FIN : C_CONT);
    end
  endtask

  task automatic burst_read(input int n, output logic [7:0] got [0:7]);
    target_cfg = {SADDR, 1'b1};
    for (int i = 0; i < n; i++) begin
      run_cmd(n == 1 ? C_SINGLE : i == 0 ? C_BSTART : i == n - 1 ? C_FIN : C_CONT);
      got[i] = rx_byte;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d [0:7];
    logic [7:0] g [0:7];
    int seed, base;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state
    chk(!st_busy && !sda_low && !scl_low && !st_err, "R6 reset", {st_busy, sda_low, scl_low, st_err}, 0);
    chk(!st_bus_busy, "R11 reset bus idle", st_bus_busy, 0);

    // R6 continue while bus not held is ignored
    cmd_code = C_CONT; cmd_stb = 1; @(negedge clk); cmd_stb = 0; @(negedge clk);
    chk(!st_busy && !scl_low, "R6 cont without hold ignored", st_busy, 0);

    // R1 R3 single send
    wcnt = 0; target_cfg = {SADDR, 1'b0}; tx_byte = 8'hA7;
    @(negedge clk); cmd_code = C_SINGLE; cmd_stb = 1; @(negedge clk); cmd_stb = 0;
    repeat (60) @(negedge clk);
    chk(st_bus_busy, "R11 bus busy during own transfer", st_bus_busy, 1);
    while (st_busy) @(negedge clk);
    chk(wcnt == 1 && wlog[0] == 8'hA7, "R1 single send byte", wlog[0], 8'hA7);
    chk(!s_act && !st_bus_busy && !scl_low, "R3 single ends with stop", {s_act, st_bus_busy}, 0);
    chk(!st_err, "R1 address acknowledged", st_err, 0);

    // R3 R4 burst write, held between commands
    wcnt = 0; target_cfg = {SADDR, 1'b0}; tx_byte = 8'h10; run_cmd(C_BSTART);
    chk(scl_low && s_act && st_bus_busy && !st_busy, "R3 burst start holds bus", {scl_low, s_act}, 3);
    tx_byte = 8'h21; run_cmd(C_CONT);
    chk(wcnt == 2 && wlog[1] == 8'h21 && starts > 0 && s_act, "R4 continue byte", wlog[1], 8'h21);
    tx_byte = 8'h32; run_cmd(C_FIN);
    chk(wcnt == 3 && wlog[2] == 8'h32 && !s_act, "R3 finish byte then stop", wlog[2], 8'h32);

    // R5 burst read ack pattern
    ack_cnt = 0; nack_cnt = 0;
    burst_read(4, g);
    for (int i = 0; i < 4; i++) chk(g[i] == rd_val(i), "R5 read byte", g[i], rd_val(i));
    chk(ack_cnt == 3 && nack_cnt == 1, "R5 ack then final nack", ack_cnt * 16 + nack_cnt, 8'h31);
    burst_read(1, g); base = last_dur;
    chk(g[0] == rd_val(0), "R5 single receive", g[0], rd_val(0));

    // R6 strobe held across end of operation
    wcnt = 0; target_cfg = {SADDR, 1'b0}; tx_byte = 8'h11;
    @(negedge clk); cmd_code = C_BSTART; cmd_stb = 1;
    @(negedge clk); cmd_code = C_FIN; tx_byte = 8'h22;
    while (st_busy) @(negedge clk);
    @(negedge clk);
    chk(st_busy, "R6 strobe accepted cycle after busy fell", st_busy, 1);
    cmd_stb = 0;
    while (st_busy) @(negedge clk);
    chk(wcnt == 2 && wlog[0] == 8'h11 && wlog[1] == 8'h22 && !s_act, "R6 strobes while busy ignored", wcnt, 2);

    // R8 address nack held, then error-stop
    err_seen_busy = 0; target_cfg = {7'h33, 1'b0}; run_cmd(C_BSTART);
    chk(st_addr_nack && st_err && !st_data_nack, "R8 address nack flags", {st_addr_nack, st_err}, 3);
    chk(scl_low && st_bus_busy, "R8 bus kept after nack", scl_low, 1);
    run_cmd(C_ESTOP);
    chk(!scl_low && !sda_low && !st_bus_busy && !st_err, "R8 error-stop frees bus", {scl_low, st_bus_busy}, 0);
    chk(!err_seen_busy, "R7 errors masked while busy", err_seen_busy, 0);
    target_cfg = {7'h33, 1'b0}; run_cmd(C_SINGLE);
    chk(st_addr_nack && !st_bus_busy && !scl_low, "R8 single nack stops", {st_addr_nack, st_bus_busy}, 2);

    // R9 data nack
    wcnt = 0; nack_at = 1; target_cfg = {SADDR, 1'b0};
    tx_byte = 8'h44; run_cmd(C_BSTART);
    chk(!st_err, "R9 first byte acked", st_err, 0);
    tx_byte = 8'h55; run_cmd(C_CONT);
    chk(st_data_nack && st_err && !st_addr_nack && scl_low, "R9 data nack held", {st_data_nack, scl_low}, 3);
    run_cmd(C_ESTOP);
    chk(!st_bus_busy && !scl_low, "R9 error-stop", st_bus_busy, 0);
    nack_at = -1;

    // R13 repeated start: write register index then read
    wcnt = 0; starts = 0; target_cfg = {SADDR, 1'b0}; tx_byte = 8'h07; run_cmd(C_BSTART);
    target_cfg = {SADDR, 1'b1}; run_cmd(C_SINGLE);
    chk(starts == 2 && wcnt == 1 && rx_byte == rd_val(0), "R13 repeated start read", rx_byte, rd_val(0));

    // R12 clock stretching
    stretch_en = 1; burst_read(1, g); stretch_en = 0;
    chk(g[0] == rd_val(0), "R12 stretched read data", g[0], rd_val(0));
    chk(last_dur > base + STR, "R12 waited for stretched clock", last_dur, base + STR);

    // R10 R11 arbitration against another master
    @(negedge clk); rogue = 1; repeat (4) @(negedge clk);
    chk(st_bus_busy, "R11 foreign start seen", st_bus_busy, 1);
    target_cfg = {7'h55, 1'b0}; run_cmd(C_BSTART);
    chk(st_arb_lost && st_err && !st_addr_nack, "R10 arbitration lost flag", st_arb_lost, 1);
    chk(!scl_low && !sda_low && !st_busy, "R10 lines released", {scl_low, sda_low}, 0);
    run_cmd(C_CONT);
    chk(last_dur == 1 && st_arb_lost, "R10 continue after loss ignored", last_dur, 1);
    chk(st_bus_busy, "R11 bus still owned by other master", st_bus_busy, 1);
    rogue = 0; repeat (4) @(negedge clk);
    chk(!st_bus_busy, "R11 foreign stop seen", st_bus_busy, 0);

    // R2 R4 R5 random burst traffic
    for (int it = 0; it < 8; it++) begin
      int n;
      n = 1 + int'($urandom % 5);
      if ($urandom % 2) begin
        wcnt = 0;
        for (int i = 0; i < n; i++) d[i] = 8'($urandom);
        burst_write(n, d);
        for (int i = 0; i < n; i++) chk(wlog[i] == d[i], "R4 random write", wlog[i], d[i]);
        chk(wcnt == n && !s_act, "R2 write length and stop", wcnt, n);
      end else begin
        burst_read(n, g);
        for (int i = 0; i < n; i++) chk(g[i] == rd_val(i), "R5 random read", g[i], rd_val(i));
        chk(!st_bus_busy, "R2 read ends with stop", st_bus_busy, 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule